// File: doc/BRIEF.md
# Integer Instruction Decode and Execute Stage

This block takes one 32-bit fixed-length instruction word together with the two register operand values already fetched for it. It decodes a small set of integer operations, works out the result, and registers the result, its destination register index and a write enable. A register file would sit in front of the block and take the write back from its outputs. Memory access, branches and jumps belong elsewhere.

Two instruction shapes are recognised. A zero in the top six bits marks a register-to-register operation, and the low six bits then name the operation. Any other top-six-bit value names an operation that takes a 16-bit immediate from the low half of the word. The two shapes write their result to different fields. Each immediate operation has its own rule for widening its constant. Encodings that are not recognised, or that are malformed, raise an error flag and write nothing.

The result appears one clock after the instruction is presented with its valid input high. A synchronous reset clears the registered valid, write-enable and error outputs.

Top module: `dx_exec_stage`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs have `out_valid`, `out_wen` and `out_illegal` at 0, and `out_result` and `out_dest` at 0.
- R2: When opcode bits [31:26] are 0 and funct bits [5:0] are 32, the result is `src_a + src_b` modulo 2^32, and the destination is bits [15:11].
- R3: Opcode 0 with funct 34 yields `src_a - src_b` modulo 2^32, written to bits [15:11].
- R4: Opcode 0 with funct 42 yields 1 when `src_a` is less than `src_b`, both taken as signed two's-complement, and 0 otherwise.
- R5: Opcode 0 with funct 0, 2 or 3 shifts `src_b` by bits [10:6]. Funct 0 shifts left, funct 2 shifts right filling with zeros, and funct 3 shifts right filling with the sign bit.
- R6: Opcode 8 adds `src_a` to the sign-extended immediate in bits [15:0]. The sum wraps modulo 2^32. It is written to bits [20:16].
- R7: Opcode 10 yields 1 when `src_a` is less than the sign-extended immediate, as a signed comparison, and 0 otherwise. The destination is bits [20:16].
- R8: Opcode 12 gives `src_a` AND the zero-extended immediate. Opcode 13 gives `src_a` OR the zero-extended immediate. Both write to bits [20:16].
- R9: Opcode 15 yields the immediate in result bits [31:16] with bits [15:0] zero, written to bits [20:16].
- R10: Some accepted words raise `out_illegal` and hold `out_wen` at 0. These are any other opcode, any other funct under opcode 0, a shift or opcode 15 whose bits [25:21] are not 0, and a non-shift opcode-0 operation whose bits [10:6] are not 0.
- R11: A legal instruction whose destination index is 0 reports `out_valid`=1, `out_illegal`=0 and `out_wen`=0.
- R12: The outputs follow the word presented one rising edge earlier. When `in_valid` was 0 at that edge, `out_valid`, `out_wen` and `out_illegal` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction and operands are present this cycle |
| insn | input | 32 | Instruction word |
| src_a | input | 32 | Value of the register named by bits [25:21] |
| src_b | input | 32 | Value of the register named by bits [20:16] |
| out_valid | output | 1 | Registered result corresponds to an accepted instruction |
| out_wen | output | 1 | Write the result back to `out_dest` |
| out_dest | output | 5 | Destination register index |
| out_result | output | 32 | Computed result |
| out_illegal | output | 1 | Accepted instruction was unrecognised or malformed |

## Verification
The only state inside the block is the single result register, so any fault in the decode path shows up at the ports one edge after the word that triggers it. A wrong decode shows up in one of three ways. It can select the wrong destination field (rd instead of rt). It can widen the immediate with the wrong rule, which shows as wrong upper result bits for negative constants or for AND and OR constants. It can mark an encoding legal or illegal wrongly, which shows on `out_illegal` and `out_wen` in that same cycle. Operand values are chosen so that each faulty variant gives a different result: for example, signed and unsigned comparison disagree, and arithmetic and logical right shift differ.

// File: rtl/dx_pkg.sv
package dx_pkg;

  localparam int XLEN     = 32;
  localparam int IMM_W    = 16;
  localparam int RIDX_W   = 5;
  localparam int SHAMT_W  = 5;
  localparam int OPC_W    = 6;
  localparam int FUNCT_W  = 6;
  localparam int EXT_PAD  = XLEN - IMM_W;

  // Field positions; the register file and this decoder both depend on them
  localparam int OPC_LSB   = 26;
  localparam int RS_LSB    = 21;
  localparam int RT_LSB    = 16;
  localparam int RD_LSB    = 11;
  localparam int SHAMT_LSB = 6;

  localparam logic [OPC_W-1:0] OPC_REG  = 6'd0;
  localparam logic [OPC_W-1:0] OPC_ADDI = 6'd8;
  localparam logic [OPC_W-1:0] OPC_SLTI = 6'd10;
  localparam logic [OPC_W-1:0] OPC_ANDI = 6'd12;
  localparam logic [OPC_W-1:0] OPC_ORI  = 6'd13;
  localparam logic [OPC_W-1:0] OPC_LUI  = 6'd15;

  localparam logic [FUNCT_W-1:0] FN_SLL = 6'd0;
  localparam logic [FUNCT_W-1:0] FN_SRL = 6'd2;
  localparam logic [FUNCT_W-1:0] FN_SRA = 6'd3;
  localparam logic [FUNCT_W-1:0] FN_ADD = 6'd32;
  localparam logic [FUNCT_W-1:0] FN_SUB = 6'd34;
  localparam logic [FUNCT_W-1:0] FN_SLT = 6'd42;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_SLT, ALU_SLL, ALU_SRL, ALU_SRA,
    ALU_OR, ALU_AND, ALU_PASSB, ALU_NONE
  } alu_op_e;

  typedef enum logic [1:0] {
    EXT_SIGN, EXT_ZERO, EXT_HIGH
  } ext_kind_e;

  typedef struct packed {
    alu_op_e   op;
    ext_kind_e ext;
    logic      use_imm;
    logic      dest_is_rt;
    logic      illegal;
  } dec_ctrl_t;

  function automatic logic [XLEN-1:0] widen_imm(input logic [IMM_W-1:0] imm,
                                                input ext_kind_e kind);
    case (kind)
      EXT_SIGN: return {{EXT_PAD{imm[IMM_W-1]}}, imm};
      EXT_ZERO: return {{EXT_PAD{1'b0}}, imm};
      default:  return {imm, {EXT_PAD{1'b0}}};
    endcase
  endfunction

  function automatic logic [XLEN-1:0] signed_below(input logic [XLEN-1:0] a,
                                                   input logic [XLEN-1:0] b);
    logic lt;
    lt = $signed(a) < $signed(b);
    return {{(XLEN-1){1'b0}}, lt};
  endfunction

  function automatic logic [XLEN-1:0] shift_word(input logic [XLEN-1:0] v,
                                                 input logic [SHAMT_W-1:0] d,
                                                 input logic right,
                                                 input logic arith);
    logic signed [XLEN-1:0] sv;
    sv = $signed(v);
    if (!right)     return v << d;
    else if (arith) return sv >>> d;
    else            return v >> d;
  endfunction

endpackage

// File: rtl/dx_field_decode.sv
module dx_field_decode
  import dx_pkg::*;
(
  input  logic [XLEN-1:0]    insn,
  output dec_ctrl_t          ctrl,
  output logic [RIDX_W-1:0]  dest,
  output logic [SHAMT_W-1:0] shamt,
  output logic [IMM_W-1:0]   imm,
  output logic               is_lui,
  output logic               is_shift
);

  logic [OPC_W-1:0]   opcode;
  logic [RIDX_W-1:0]  rs_f;
  logic [RIDX_W-1:0]  rt_f;
  logic [RIDX_W-1:0]  rd_f;
  logic [FUNCT_W-1:0] funct;

  assign opcode = insn[OPC_LSB +: OPC_W];
  assign rs_f   = insn[RS_LSB +: RIDX_W];
  assign rt_f   = insn[RT_LSB +: RIDX_W];
  assign rd_f   = insn[RD_LSB +: RIDX_W];
  assign shamt  = insn[SHAMT_LSB +: SHAMT_W];
  assign funct  = insn[FUNCT_W-1:0];
  assign imm    = insn[IMM_W-1:0];

  logic rs_zero;
  logic shamt_zero;
  assign rs_zero    = (rs_f == '0);
  assign shamt_zero = (shamt == '0);

  always_comb begin
    ctrl.op         = ALU_NONE;
    ctrl.ext        = EXT_SIGN;
    ctrl.use_imm    = 1'b0;
    ctrl.dest_is_rt = 1'b0;
    ctrl.illegal    = 1'b1;
    is_lui          = 1'b0;
    is_shift        = 1'b0;
    case (opcode)
      OPC_REG: begin
        ctrl.illegal = 1'b0;
        case (funct)
          FN_ADD: ctrl.op = ALU_ADD;
          FN_SUB: ctrl.op = ALU_SUB;
          FN_SLT: ctrl.op = ALU_SLT;
          FN_SLL: begin ctrl.op = ALU_SLL; is_shift = 1'b1; end
          FN_SRL: begin ctrl.op = ALU_SRL; is_shift = 1'b1; end
          FN_SRA: begin ctrl.op = ALU_SRA; is_shift = 1'b1; end
          default: ctrl.illegal = 1'b1;
        endcase
        if (is_shift && !rs_zero)
          ctrl.illegal = 1'b1;
        if (!is_shift && !shamt_zero)
          ctrl.illegal = 1'b1;
      end
      OPC_ADDI: begin
        ctrl.op = ALU_ADD; ctrl.ext = EXT_SIGN;
        ctrl.use_imm = 1'b1; ctrl.dest_is_rt = 1'b1; ctrl.illegal = 1'b0;
      end
      OPC_SLTI: begin
        ctrl.op = ALU_SLT; ctrl.ext = EXT_SIGN;
        ctrl.use_imm = 1'b1; ctrl.dest_is_rt = 1'b1; ctrl.illegal = 1'b0;
      end
      OPC_ANDI: begin
        ctrl.op = ALU_AND; ctrl.ext = EXT_ZERO;
        ctrl.use_imm = 1'b1; ctrl.dest_is_rt = 1'b1; ctrl.illegal = 1'b0;
      end
      OPC_ORI: begin
        ctrl.op = ALU_OR; ctrl.ext = EXT_ZERO;
        ctrl.use_imm = 1'b1; ctrl.dest_is_rt = 1'b1; ctrl.illegal = 1'b0;
      end
      OPC_LUI: begin
        ctrl.op = ALU_PASSB; ctrl.ext = EXT_HIGH;
        ctrl.use_imm = 1'b1; ctrl.dest_is_rt = 1'b1;
        ctrl.illegal = !rs_zero;
        is_lui = 1'b1;
      end
      default: ctrl.illegal = 1'b1;
    endcase
  end

  assign dest = ctrl.dest_is_rt ? rt_f : rd_f;

endmodule

// File: rtl/dx_imm_extend.sv
module dx_imm_extend
  import dx_pkg::*;
(
  input  logic [IMM_W-1:0] imm,
  input  ext_kind_e        kind,
  output logic [XLEN-1:0]  wide
);

  assign wide = widen_imm(imm, kind);

endmodule

// File: rtl/dx_alu.sv
module dx_alu
  import dx_pkg::*;
(
  input  alu_op_e            op,
  input  logic [XLEN-1:0]    opa,
  input  logic [XLEN-1:0]    opb_reg,
  input  logic [XLEN-1:0]    opb_imm,
  input  logic               use_imm,
  input  logic [SHAMT_W-1:0] shamt,
  output logic [XLEN-1:0]    result
);

  logic [XLEN-1:0] opb;
  assign opb = use_imm ? opb_imm : opb_reg;

  always_comb begin
    case (op)
      ALU_ADD:   result = opa + opb;
      ALU_SUB:   result = opa - opb;
      ALU_SLT:   result = signed_below(opa, opb);
      ALU_SLL:   result = shift_word(opb_reg, shamt, 1'b0, 1'b0);
      ALU_SRL:   result = shift_word(opb_reg, shamt, 1'b1, 1'b0);
      ALU_SRA:   result = shift_word(opb_reg, shamt, 1'b1, 1'b1);
      ALU_OR:    result = opa | opb;
      ALU_AND:   result = opa & opb;
      ALU_PASSB: result = opb;
      default:   result = '0;
    endcase
  end

endmodule

// File: rtl/dx_exec_stage.sv
module dx_exec_stage
  import dx_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [XLEN-1:0]         insn,
  input  logic [XLEN-1:0]         src_a,
  input  logic [XLEN-1:0]         src_b,
  output logic                    out_valid,
  output logic                    out_wen,
  output logic [RIDX_W-1:0]       out_dest,
  output logic [XLEN-1:0]         out_result,
  output logic                    out_illegal
);

  dec_ctrl_t          dec_ctrl;
  logic [RIDX_W-1:0]  dec_dest;
  logic [SHAMT_W-1:0] dec_shamt;
  logic [IMM_W-1:0]   dec_imm;
  logic               dec_is_lui;
  logic               dec_is_shift;
  logic               dec_illegal;
  logic               dec_dest_zero;
  logic [XLEN-1:0]    imm_wide;
  logic [XLEN-1:0]    alu_result;
  logic               wr_allowed;

  dx_field_decode u_decode (
    .insn     (insn),
    .ctrl     (dec_ctrl),
    .dest     (dec_dest),
    .shamt    (dec_shamt),
    .imm      (dec_imm),
    .is_lui   (dec_is_lui),
    .is_shift (dec_is_shift)
  );

  dx_imm_extend u_ext (
    .imm  (dec_imm),
    .kind (dec_ctrl.ext),
    .wide (imm_wide)
  );

  dx_alu u_alu (
    .op      (dec_ctrl.op),
    .opa     (src_a),
    .opb_reg (src_b),
    .opb_imm (imm_wide),
    .use_imm (dec_ctrl.use_imm),
    .shamt   (dec_shamt),
    .result  (alu_result)
  );

  assign dec_illegal   = dec_ctrl.illegal;
  assign dec_dest_zero = (dec_dest == '0);
  assign wr_allowed    = in_valid && !dec_illegal && !dec_dest_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_wen     <= 1'b0;
      out_illegal <= 1'b0;
      out_dest    <= '0;
      out_result  <= '0;
    end else begin
      out_valid   <= in_valid;
      out_wen     <= wr_allowed;
      out_illegal <= in_valid && dec_illegal;
      out_dest    <= dec_dest;
      out_result  <= alu_result;
    end
  end

endmodule

module dx_exec_stage_chk
  import dx_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [XLEN-1:0]   insn,
  input logic              out_valid,
  input logic              out_wen,
  input logic [RIDX_W-1:0] out_dest,
  input logic [XLEN-1:0]   out_result,
  input logic              out_illegal,
  input logic              dec_illegal,
  input logic              dec_is_lui,
  input logic              dec_is_shift
);

  assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && !out_wen && !out_illegal));

  assert_lui_layout_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dec_is_lui && !dec_illegal) |=>
      (out_result[IMM_W-1:0] == '0 && out_result[XLEN-1:IMM_W] == $past(insn[IMM_W-1:0])));

  assert_illegal_flagged_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dec_illegal) |=> (out_illegal && !out_wen));

  assert_illegal_no_write_R10: assert property (@(posedge clk) disable iff (rst)
    out_illegal |-> !out_wen);

  assert_shift_needs_clear_rs_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dec_is_shift && insn[RS_LSB +: RIDX_W] != '0) |=> out_illegal);

  assert_zero_dest_R11: assert property (@(posedge clk) disable iff (rst)
    out_wen |-> (out_dest != '0));

  assert_wen_needs_valid_R12: assert property (@(posedge clk) disable iff (rst)
    out_wen |-> out_valid);

  assert_valid_follows_R12: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_bubble_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !out_wen && !out_illegal));

endmodule

bind dx_exec_stage dx_exec_stage_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .insn         (insn),
  .out_valid    (out_valid),
  .out_wen      (out_wen),
  .out_dest     (out_dest),
  .out_result   (out_result),
  .out_illegal  (out_illegal),
  .dec_illegal  (dec_illegal),
  .dec_is_lui   (dec_is_lui),
  .dec_is_shift (dec_is_shift)
);

// File: tb/dx_exec_stage_tb.sv
module dx_exec_stage_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] insn = '0;
  logic [31:0] src_a = '0;
  logic [31:0] src_b = '0;
  logic        out_valid;
  logic        out_wen;
  logic [4:0]  out_dest;
  logic [31:0] out_result;
  logic        out_illegal;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dx_exec_stage u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn),
    .src_a(src_a), .src_b(src_b), .out_valid(out_valid), .out_wen(out_wen),
    .out_dest(out_dest), .out_result(out_result), .out_illegal(out_illegal)
  );

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, int sh, int fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
  endfunction

  function automatic logic [31:0] enc_i(int op, int rs, int rt, logic [15:0] k);
    return {6'(op), 5'(rs), 5'(rt), k};
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  // present one word, let one edge pass, sample after it
  task automatic issue(logic v, logic [31:0] w, logic [31:0] a, logic [31:0] b);
    @(negedge clk);
    in_valid = v; insn = w; src_a = a; src_b = b;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic expect_write(string tag, logic [4:0] d, logic [31:0] r);
    chk({tag, " valid"}, 32'(out_valid), 32'd1);
    chk({tag, " wen"}, 32'(out_wen), 32'd1);
    chk({tag, " illegal"}, 32'(out_illegal), 32'd0);
    chk({tag, " dest"}, 32'(out_dest), 32'(d));
    chk({tag, " result"}, out_result, r);
  endtask

  task automatic expect_illegal(string tag);
    chk({tag, " valid"}, 32'(out_valid), 32'd1);
    chk({tag, " illegal"}, 32'(out_illegal), 32'd1);
    chk({tag, " wen"}, 32'(out_wen), 32'd0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 valid", 32'(out_valid), 0);
    chk("R1 wen", 32'(out_wen), 0);
    chk("R1 illegal", 32'(out_illegal), 0);
    chk("R1 result", out_result, 0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_reset_midrun();
    issue(1'b1, enc_r(1, 2, 9, 0, 32), 32'd5, 32'd6);
    @(negedge clk); rst = 1'b1; in_valid = 1'b1;
    @(posedge clk); #1;
    chk("R1 midrun valid", 32'(out_valid), 0);
    chk("R1 midrun wen", 32'(out_wen), 0);
    chk("R1 midrun dest", 32'(out_dest), 0);
    @(negedge clk); rst = 1'b0; in_valid = 1'b0;
  endtask

  task automatic t_add();
    issue(1'b1, enc_r(3, 4, 7, 0, 32), 32'd100, 32'd23);
    expect_write("R2 add", 5'd7, 32'd123);
    issue(1'b1, enc_r(3, 4, 31, 0, 32), 32'hFFFF_FFFF, 32'd2);
    expect_write("R2 add wrap", 5'd31, 32'd1);
  endtask

  task automatic t_sub();
    issue(1'b1, enc_r(1, 2, 5, 0, 34), 32'd10, 32'd3);
    expect_write("R3 sub", 5'd5, 32'd7);
    issue(1'b1, enc_r(1, 2, 5, 0, 34), 32'd0, 32'd1);
    expect_write("R3 sub wrap", 5'd5, 32'hFFFF_FFFF);
  endtask

  task automatic t_slt();
    issue(1'b1, enc_r(1, 2, 6, 0, 42), 32'hFFFF_FFFE, 32'd1);
    expect_write("R4 slt neg<pos", 5'd6, 32'd1);
    issue(1'b1, enc_r(1, 2, 6, 0, 42), 32'd1, 32'h8000_0000);
    expect_write("R4 slt pos>min", 5'd6, 32'd0);
    issue(1'b1, enc_r(1, 2, 6, 0, 42), 32'd9, 32'd9);
    expect_write("R4 slt equal", 5'd6, 32'd0);
  endtask

  task automatic t_shift();
    logic [31:0] v;
    v = 32'h8000_00F0;
    issue(1'b1, enc_r(0, 2, 8, 4, 0), 32'hDEAD_BEEF, v);
    expect_write("R5 sll", 5'd8, v << 4);
    issue(1'b1, enc_r(0, 2, 8, 31, 2), 32'd0, v);
    expect_write("R5 srl 31", 5'd8, 32'd1);
    issue(1'b1, enc_r(0, 2, 8, 4, 3), 32'd0, v);
    expect_write("R5 sra", 5'd8, 32'hF800_000F);
    issue(1'b1, enc_r(0, 2, 8, 0, 3), 32'd0, v);
    expect_write("R5 sra 0", 5'd8, v);
  endtask

  task automatic t_addi();
    issue(1'b1, enc_i(8, 22, 21, 16'hFFCE), 32'd100, 32'hAAAA_AAAA);
    expect_write("R6 addi neg", 5'd21, 32'd50);
    issue(1'b1, enc_i(8, 22, 3, 16'h7FFF), 32'd1, 32'd0);
    expect_write("R6 addi pos", 5'd3, 32'h0000_8000);
  endtask

  task automatic t_slti();
    issue(1'b1, enc_i(10, 1, 4, 16'hFFFF), 32'hFFFF_FFFE, 32'd0);
    expect_write("R7 slti -2<-1", 5'd4, 32'd1);
    issue(1'b1, enc_i(10, 1, 4, 16'h8000), 32'd5, 32'd0);
    expect_write("R7 slti 5<min", 5'd4, 32'd0);
  endtask

  task automatic t_logic_imm();
    issue(1'b1, enc_i(12, 1, 11, 16'hF0F0), 32'hFFFF_FFFF, 32'd0);
    expect_write("R8 andi", 5'd11, 32'h0000_F0F0);
    issue(1'b1, enc_i(13, 1, 12, 16'h8001), 32'h1234_0000, 32'd0);
    expect_write("R8 ori", 5'd12, 32'h1234_8001);
  endtask

  task automatic t_lui();
    issue(1'b1, enc_i(15, 0, 10, 16'hABCD), 32'hFFFF_FFFF, 32'h1111_1111);
    expect_write("R9 lui", 5'd10, 32'hABCD_0000);
  endtask

  task automatic t_illegal();
    issue(1'b1, enc_i(2, 1, 2, 16'h0004), 32'd1, 32'd1);
    expect_illegal("R10 jump opcode");
    issue(1'b1, enc_r(1, 2, 3, 0, 8), 32'd1, 32'd1);
    expect_illegal("R10 bad funct");
    issue(1'b1, enc_r(4, 2, 3, 1, 0), 32'd1, 32'd1);
    expect_illegal("R10 shift rs");
    issue(1'b1, enc_r(1, 2, 3, 2, 32), 32'd1, 32'd1);
    expect_illegal("R10 add shamt");
    issue(1'b1, enc_i(15, 7, 3, 16'h1234), 32'd1, 32'd1);
    expect_illegal("R10 lui rs");
  endtask

  task automatic t_zero_dest();
    issue(1'b1, enc_r(1, 2, 0, 0, 32), 32'd4, 32'd4);
    chk("R11 rd0 valid", 32'(out_valid), 1);
    chk("R11 rd0 wen", 32'(out_wen), 0);
    chk("R11 rd0 illegal", 32'(out_illegal), 0);
    issue(1'b1, enc_i(8, 1, 0, 16'h0001), 32'd4, 32'd4);
    chk("R11 rt0 wen", 32'(out_wen), 0);
    chk("R11 rt0 illegal", 32'(out_illegal), 0);
  endtask

  task automatic t_bubble();
    issue(1'b0, enc_r(1, 2, 3, 0, 32), 32'd1, 32'd2);
    chk("R12 bubble valid", 32'(out_valid), 0);
    chk("R12 bubble wen", 32'(out_wen), 0);
    issue(1'b0, enc_i(63, 1, 2, 16'h0), 32'd1, 32'd2);
    chk("R12 bubble illegal", 32'(out_illegal), 0);
    issue(1'b1, enc_r(1, 2, 3, 0, 32), 32'd1, 32'd2);
    expect_write("R12 one edge", 5'd3, 32'd3);
    @(posedge clk); #1;
    chk("R12 drops after", 32'(out_valid), 0);
  endtask

  initial begin
    t_reset();
    t_add();
    t_sub();
    t_slt();
    t_shift();
    t_addi();
    t_slti();
    t_logic_imm();
    t_lui();
    t_illegal();
    t_zero_dest();
    t_bubble();
    t_reset_midrun();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired got running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule